// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver with Pixel Blink

This block produces the time-multiplexed drive state for a passive LCD panel. A common-plane sequencer steps through either four commons (quarter duty) or three commons (third duty). On each step it reports which common is active, both as an index and as a one-hot vector. It also presents the segment bit vector that belongs to that common. Analog bias levels and waveform voltages are produced elsewhere from these digital outputs.

Pixel state is held in a frame store with one 4-bit word per segment line. Bit c of a word is the pixel at the crossing of that segment and common c. The store is loaded through a plain write port, with the segment number as the address.

Two fixed segment lines (18 and 19) can blink. Each has a 4-bit mask with one bit per common, and a set bit selects that pixel for blinking. A slow tick input drives the blink timebase. With the default tick of 4 Hz, the blink runs at 1 Hz or 0.5 Hz. In the hidden half of the blink period, masked pixels read as off. In the visible half, they show their stored value.

Top module: `lcd_mux_blink`

## Requirements
- R1: After reset, com_idx is 0, com_onehot is 4'b0001, every seg_out bit is 0 and the blink state is in its visible half.
- R2: A cycle with wr_en high and wr_addr below 35 stores wr_data as the word of segment wr_addr. Bit c of that word is the pixel on common c. From the next cycle on, seg_out[wr_addr] shows the bit for the active common.
- R3: With duty3 low, each frame_tick cycle moves com_idx one step along 0,1,2,3, and 3 is followed by 0.
- R4: With duty3 high, com_idx steps 0,1,2 and 2 is followed by 0. An index of 3 that remains when duty3 is raised also returns to 0 on the next frame_tick.
- R5: com_onehot has exactly one bit set, the bit at position com_idx.
- R6: A write with wr_addr of 35 or above changes no stored pixel.
- R7: While the blink state is in its hidden half, seg_out[18] reads 0 whenever blink_mask_a[com_idx] is 1, and seg_out[19] reads 0 whenever blink_mask_b[com_idx] is 1. In the visible half, both show their stored values.
- R8: Segments other than 18 and 19 never blink. Pixels on 18 and 19 whose mask bit is 0 also never blink.
- R9: With blink_slow low, the blink state toggles on every 2nd blink_tick (1 Hz at a 4 Hz tick). With blink_slow high, it toggles on every 4th blink_tick (0.5 Hz).
- R10: Stored pixels are kept unchanged across changes of duty3, blink_slow and the masks.
- R11: Without frame_tick, com_idx holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse that advances the common phase |
| blink_tick | input | 1 | One-cycle pulse from the blink timebase (4 Hz nominal) |
| duty3 | input | 1 | 1: three commons, 0: four commons |
| blink_slow | input | 1 | 1: 0.5 Hz blink, 0: 1 Hz blink |
| wr_en | input | 1 | Frame store write strobe |
| wr_addr | input | 6 | Segment number to write |
| wr_data | input | 4 | Pixel bits, bit c for common c |
| blink_mask_a | input | 4 | Blink mask of segment 18, one bit per common |
| blink_mask_b | input | 4 | Blink mask of segment 19, one bit per common |
| com_idx | output | 2 | Active common index |
| com_onehot | output | 4 | Active common as one-hot vector |
| seg_out | output | 35 | Segment values for the active common |

## Verification
All state sits in one register stage, and the outputs are combinational from that state. A write, a frame_tick or a blink_tick applied before a rising edge therefore shows on the outputs right after that edge. Mask and rate inputs act without delay, because they only steer combinational logic. The bench drives every input on the falling edge and compares outputs at the next falling edge, one full register stage later. The blink checks count ticks from a known phase of the blink counter, so the toggle is expected on exactly the 2nd or 4th tick.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } blink_rate_e;

  typedef enum logic {
    BLINK_SHOW = 1'b0,
    BLINK_HIDE = 1'b1
  } blink_half_e;
endpackage

// File: rtl/lcd_com_seq.sv
module lcd_com_seq #(
  parameter int NUM_COM = 4,
  parameter int COM_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic               short_frame,
  output logic [COM_W-1:0]   com_idx,
  output logic [NUM_COM-1:0] com_onehot
);
  localparam logic [COM_W-1:0] LAST_FULL  = COM_W'(NUM_COM - 1);
  localparam logic [COM_W-1:0] LAST_SHORT = COM_W'(NUM_COM - 2);

  logic [COM_W-1:0] phase_q, phase_d;
  logic [COM_W-1:0] last_phase;

  always_comb begin
    last_phase = short_frame ? LAST_SHORT : LAST_FULL;
    phase_d    = phase_q;
    if (frame_tick) begin
      if (phase_q >= last_phase) phase_d = '0;
      else                       phase_d = phase_q + COM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (frame_tick) phase_q <= phase_d;
  end

  assign com_idx = phase_q;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_onehot
    assign com_onehot[c] = (phase_q == COM_W'(c));
  end
endmodule

// File: rtl/lcd_frame_mem.sv
module lcd_frame_mem #(
  parameter int NUM_SEG = 35,
  parameter int NUM_COM = 4,
  parameter int COM_W   = 2,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_COM-1:0] wr_data,
  input  logic [COM_W-1:0]   com_sel,
  output logic [NUM_SEG-1:0] seg_raw
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_word
    logic [NUM_COM-1:0] word_q, word_d;
    logic               hit;

    always_comb begin
      hit    = wr_en && (wr_addr == ADDR_W'(s));
      word_d = hit ? wr_data : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= word_d;
    end

    assign seg_raw[s] = word_q[com_sel];
  end
endmodule

// File: rtl/lcd_blink_gen.sv
module lcd_blink_gen
  import lcd_mux_pkg::*;
#(
  parameter int HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blink_tick,
  input  blink_rate_e rate,
  output blink_half_e half
);
  localparam int HALF_SLOW = 2 * HALF_FAST;
  localparam int CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(HALF_SLOW - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  blink_half_e      half_q, half_d;

  always_comb begin
    limit  = (rate == RATE_SLOW) ? LIM_SLOW : LIM_FAST;
    cnt_d  = cnt_q;
    half_d = half_q;
    if (blink_tick) begin
      if (cnt_q >= limit) begin
        cnt_d  = '0;
        half_d = (half_q == BLINK_SHOW) ? BLINK_HIDE : BLINK_SHOW;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= BLINK_SHOW;
    end else if (blink_tick) begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign half = half_q;
endmodule

// File: rtl/lcd_mux_blink.sv
module lcd_mux_blink
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 35,
  parameter int NUM_COM     = 4,
  parameter int BLINK_SEG_A = 18,
  parameter int BLINK_SEG_B = 19,
  parameter int HALF_FAST   = 2,
  localparam int COM_W      = $clog2(NUM_COM),
  localparam int ADDR_W     = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic               blink_tick,
  input  logic               duty3,
  input  logic               blink_slow,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_COM-1:0] wr_data,
  input  logic [NUM_COM-1:0] blink_mask_a,
  input  logic [NUM_COM-1:0] blink_mask_b,
  output logic [COM_W-1:0]   com_idx,
  output logic [NUM_COM-1:0] com_onehot,
  output logic [NUM_SEG-1:0] seg_out
);
  logic [NUM_SEG-1:0] seg_raw;
  blink_half_e        half;
  blink_rate_e        rate;

  assign rate = blink_slow ? RATE_SLOW : RATE_FAST;

  lcd_com_seq #(
    .NUM_COM (NUM_COM),
    .COM_W   (COM_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .short_frame(duty3),
    .com_idx    (com_idx),
    .com_onehot (com_onehot)
  );

  lcd_frame_mem #(
    .NUM_SEG (NUM_SEG),
    .NUM_COM (NUM_COM),
    .COM_W   (COM_W),
    .ADDR_W  (ADDR_W)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .com_sel (com_idx),
    .seg_raw (seg_raw)
  );

  lcd_blink_gen #(
    .HALF_FAST (HALF_FAST)
  ) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_tick (blink_tick),
    .rate       (rate),
    .half       (half)
  );

  always_comb begin
    seg_out = seg_raw;
    if (half == BLINK_HIDE) begin
      if (blink_mask_a[com_idx]) seg_out[BLINK_SEG_A] = 1'b0;
      if (blink_mask_b[com_idx]) seg_out[BLINK_SEG_B] = 1'b0;
    end
  end
endmodule

// File: rtl/lcd_mux_blink_chk.sv
module lcd_mux_blink_chk #(
  parameter int NUM_SEG     = 35,
  parameter int NUM_COM     = 4,
  parameter int BLINK_SEG_A = 18,
  parameter int BLINK_SEG_B = 19,
  parameter int COM_W       = 2,
  parameter int ADDR_W      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_tick,
  input logic               duty3,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [COM_W-1:0]   com_idx,
  input logic [NUM_COM-1:0] com_onehot,
  input logic [NUM_SEG-1:0] seg_out
);
  function automatic logic [NUM_SEG-1:0] steady_mask();
    logic [NUM_SEG-1:0] m;
    m = '1;
    m[BLINK_SEG_A] = 1'b0;
    m[BLINK_SEG_B] = 1'b0;
    return m;
  endfunction

  localparam logic [NUM_SEG-1:0] STEADY = steady_mask();

  // R5
  onehot_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_onehot) == 1 && com_onehot[com_idx]);

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(com_idx));

  // R3
  step_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !duty3 && com_idx < COM_W'(NUM_COM - 1))
      |=> com_idx == $past(com_idx) + COM_W'(1));

  // R3
  wrap_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !duty3 && com_idx == COM_W'(NUM_COM - 1)) |=> com_idx == '0);

  // R4
  wrap_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && duty3 && com_idx >= COM_W'(NUM_COM - 2)) |=> com_idx == '0);

  // R8
  steady_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !frame_tick) |=> $stable(seg_out & STEADY));

  // R6
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(NUM_SEG) && !frame_tick) |=> $stable(seg_out & STEADY));
endmodule

bind lcd_mux_blink lcd_mux_blink_chk #(
  .NUM_SEG     (NUM_SEG),
  .NUM_COM     (NUM_COM),
  .BLINK_SEG_A (BLINK_SEG_A),
  .BLINK_SEG_B (BLINK_SEG_B),
  .COM_W       (COM_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .duty3      (duty3),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .com_idx    (com_idx),
  .com_onehot (com_onehot),
  .seg_out    (seg_out)
);

// File: tb/tb_lcd_mux_blink.sv
module tb_lcd_mux_blink;
  localparam int NSEG = 35;

  logic        clk;
  logic        rst_n;
  logic        frame_tick, blink_tick, duty3, blink_slow, wr_en;
  logic [5:0]  wr_addr;
  logic [3:0]  wr_data, blink_mask_a, blink_mask_b;
  logic [1:0]  com_idx;
  logic [3:0]  com_onehot;
  logic [NSEG-1:0] seg_out;

  int n_chk;
  int n_bad;

  logic [3:0] m_mem [NSEG];
  int         m_phase;
  bit         m_hide;

  lcd_mux_blink dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .blink_tick(blink_tick),
    .duty3(duty3), .blink_slow(blink_slow), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .blink_mask_a(blink_mask_a), .blink_mask_b(blink_mask_b),
    .com_idx(com_idx), .com_onehot(com_onehot), .seg_out(seg_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [NSEG-1:0] exp_seg();
    logic [NSEG-1:0] v;
    for (int s = 0; s < NSEG; s++) v[s] = m_mem[s][m_phase];
    if (m_hide) begin
      if (blink_mask_a[m_phase]) v[18] = 1'b0;
      if (blink_mask_b[m_phase]) v[19] = 1'b0;
    end
    return v;
  endfunction

  task automatic check_outputs(string req);
    logic [NSEG-1:0] es;
    logic [3:0] eoh;
    es  = exp_seg();
    eoh = 4'b0001 << m_phase;
    n_chk++;
    if (com_idx !== 2'(m_phase)) begin
      n_bad++;
      $display("FAIL %s com_idx actual=%0d expected=%0d", req, com_idx, m_phase);
    end
    n_chk++;
    if (com_onehot !== eoh) begin
      n_bad++;
      $display("FAIL %s com_onehot actual=%b expected=%b", req, com_onehot, eoh);
    end
    n_chk++;
    if (seg_out !== es) begin
      n_bad++;
      $display("FAIL %s seg_out actual=%h expected=%h", req, seg_out, es);
    end
  endtask

  task automatic write_px(int a, logic [3:0] d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NSEG) m_mem[a] = d;
  endtask

  task automatic frame_adv();
    int last;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    last = duty3 ? 2 : 3;
    m_phase = (m_phase >= last) ? 0 : m_phase + 1;
  endtask

  task automatic blink_pulse();
    blink_tick = 1'b1;
    @(negedge clk);
    blink_tick = 1'b0;
  endtask

  task automatic sweep(string req);
    int n;
    n = duty3 ? 3 : 4;
    for (int k = 0; k < n; k++) begin
      check_outputs(req);
      frame_adv();
    end
  endtask

  task automatic t_reset();
    // R1: reset state
    check_outputs("R1");
    blink_mask_a = 4'hF; blink_mask_b = 4'hF;
    write_px(18, 4'hF);
    check_outputs("R1 blink visible after reset");
    write_px(18, 4'h0);
    blink_mask_a = 4'h0; blink_mask_b = 4'h0;
  endtask

  task automatic t_write_read();
    // R2: several patterns across all commons
    write_px(0, 4'b1010);
    write_px(7, 4'b0110);
    write_px(18, 4'b1001);
    write_px(19, 4'b0111);
    write_px(34, 4'b1111);
    write_px(12, 4'b0001);
    sweep("R2");
    write_px(0, 4'b0101);
    sweep("R2 overwrite");
  endtask

  task automatic t_wrap4();
    // R3 and R5: four-common sequence
    duty3 = 1'b0;
    for (int k = 0; k < 8; k++) begin
      frame_adv();
      check_outputs("R3");
    end
  endtask

  task automatic t_wrap3();
    // R4: three-common sequence and leftover phase 3
    duty3 = 1'b1;
    for (int k = 0; k < 6; k++) begin
      frame_adv();
      check_outputs("R4");
    end
    duty3 = 1'b0;
    while (m_phase != 3) frame_adv();
    check_outputs("R4 at phase 3");
    duty3 = 1'b1;
    frame_adv();
    check_outputs("R4 leftover phase 3 returns to 0");
    duty3 = 1'b0;
  endtask

  task automatic t_hold();
    // R11: no frame_tick, phase holds
    frame_adv();
    for (int k = 0; k < 5; k++) @(negedge clk);
    check_outputs("R11");
  endtask

  task automatic t_bad_addr();
    // R6: out-of-range addresses store nothing
    write_px(35, 4'hF);
    write_px(40, 4'hF);
    write_px(63, 4'hF);
    sweep("R6");
  endtask

  task automatic t_blink_fast();
    // R7 R8 R9: 1 Hz, toggle every 2nd tick
    blink_slow = 1'b0;
    write_px(17, 4'hF); write_px(18, 4'hF); write_px(19, 4'hF); write_px(20, 4'hF);
    blink_mask_a = 4'b0101; blink_mask_b = 4'b1000;
    blink_pulse(); m_hide = 0; sweep("R9 fast tick1 visible");
    blink_pulse(); m_hide = 1; sweep("R7 R8 fast tick2 hidden");
    blink_pulse(); m_hide = 1; sweep("R9 fast tick3 hidden");
    blink_pulse(); m_hide = 0; sweep("R7 fast tick4 visible");
  endtask

  task automatic t_blink_slow();
    // R9: 0.5 Hz, toggle every 4th tick
    blink_slow = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      blink_pulse();
      m_hide = (k >= 4 && k < 8);
      check_outputs($sformatf("R9 slow tick%0d", k));
    end
    blink_mask_a = 4'hF; blink_mask_b = 4'hF;
    for (int k = 1; k <= 4; k++) blink_pulse();
    m_hide = 1;
    sweep("R7 full mask hidden");
  endtask

  task automatic t_retention();
    // R10: settings changes keep the stored pixels
    blink_mask_a = 4'h0; blink_mask_b = 4'h0; m_hide_refresh();
    duty3 = 1'b1; blink_slow = 1'b0;
    sweep("R10 after duty change");
    duty3 = 1'b0;
    while (m_phase != 0) frame_adv();
    sweep("R10 back to four commons");
  endtask

  task automatic m_hide_refresh();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    m_phase = 0; m_hide = 0;
    for (int s = 0; s < NSEG; s++) m_mem[s] = 4'h0;
    rst_n = 1'b0;
    frame_tick = 0; blink_tick = 0; duty3 = 0; blink_slow = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0; blink_mask_a = '0; blink_mask_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap4();
    t_wrap3();
    t_hold();
    t_bad_addr();
    while (m_phase != 0) frame_adv();
    t_blink_fast();
    t_blink_slow();
    t_retention();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule